// File: doc/BRIEF.md
# Three-Lane 1:7 Deserializer with Failsafe

This block sits behind three serial data receivers and one forwarded frame-clock receiver. All four lines are sampled by a bit clock running at seven times the frame rate. The block finds each frame boundary from the shape of the forwarded clock and gathers seven bits from each lane. Once per frame it presents a 21-bit parallel word together with a rebuilt parallel clock, and the rising edge of that clock marks when the word is valid.

Two activity monitors watch the inputs. One declares the forwarded clock lost when it stops toggling. The other declares the data idle when the lanes stop toggling. The outputs then go to defined failsafe levels, and which levels apply depends on which input was lost first. An active-low power-down input overrides everything else: the word is driven to zero and the parallel clock is held high.

Top module: `tri_lane_deser`

## Requirements
- R1: A frame starts at the bit-clock sample where `fclk_in` reads 1 and the previous sample read 0; that sample is slot 0. The sample of `lane_in[k]` taken in slot s lands in `par_data[7k+s]`. The finished word appears on `par_data` at the clock edge that samples slot 6.
- R2: While the forwarded clock is present, `par_clk` is high after the edges that sample slots 0 to 3 and low after the edges that sample slots 4 to 6. It therefore rises one bit clock after each new word appears.
- R3: If a frame-length stretch of samples contains no 0-to-1 step on `fclk_in`, `par_data` is not updated at the end of that stretch.
- R4: When `fclk_in` has shown no transition for 16 bit clocks, `par_clk` is held at 1.
- R5: If the forwarded clock is lost while the data lanes are still active, `par_data` keeps the last complete word.
- R6: If all three lanes show no transition across 4 frame ends while the forwarded clock keeps running, `par_data` is driven to all ones and `par_clk` keeps its normal pattern.
- R7: Once the data-idle failsafe is active, a later loss of the forwarded clock keeps `par_data` at all ones and holds `par_clk` at 1.
- R8: When both the forwarded clock and lane activity return, normal words resume from the next framed word onward.
- R9: While `pwr_dn_n` is 0, `par_data` is 0 and `par_clk` is 1 from the next edge on. After release, framing restarts and words resume.
- R10: During and after synchronous reset, `par_data` is 0 and `par_clk` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the frame rate |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn_n | input | 1 | Active-low power-down |
| fclk_in | input | 1 | Sampled forwarded frame clock |
| lane_in | input | 3 | Sampled serial data lanes |
| par_data | output | 21 | Rebuilt parallel word |
| par_clk | output | 1 | Rebuilt parallel clock; rising edge strobes par_data |

## Verification
A slot counter that is wrong shows up within one frame as bits rotated between positions inside a lane, and as a `par_clk` high phase that is shifted or the wrong length. A failsafe mode that is wrong shows up as the wrong word. For example, ones appear where a held word was expected, or the held word is overwritten while no forwarded clock is arriving. This becomes visible within 16 bit clocks of losing the clock, or 4 frames after the lanes go quiet. A monitor that fails to release after recovery leaves the outputs stuck through the two recovery frames that the bench checks.

// File: rtl/deser_pkg.sv
package deser_pkg;
    localparam int LANES      = 3;
    localparam int SLOTS      = 7;
    localparam int WORD_W     = LANES * SLOTS;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int HIGH_SLOTS = 4;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [1:0] {
        FS_RUN,
        FS_HOLD,
        FS_ONES
    } fs_mode_e;

    typedef struct packed {
        slot_t slot;
        logic  commit;
        logic  frame_end;
    } frame_pos_t;

    function automatic logic clk_high_slot(slot_t s);
        return s < slot_t'(HIGH_SLOTS);
    endfunction
endpackage

// File: rtl/deser_framer.sv
module deser_framer
    import deser_pkg::*;
#(
    parameter int LOSS_BITS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       fclk_in,
    output frame_pos_t pos,
    output logic       clk_lost
);
    localparam int QW = $clog2(LOSS_BITS + 1);

    logic          fclk_prev;
    slot_t         slot_q;
    slot_t         slot_now;
    logic          framed_q;
    logic          rise;
    logic [QW-1:0] quiet_q;

    assign rise     = fclk_in & ~fclk_prev;
    assign slot_now = rise ? slot_t'(0)
                    : (slot_q == slot_t'(SLOTS-1)) ? slot_t'(0) : slot_q + slot_t'(1);

    assign pos.slot      = slot_now;
    assign pos.frame_end = (slot_now == slot_t'(SLOTS-1));
    assign pos.commit    = pos.frame_end & (rise | framed_q);
    assign clk_lost      = (quiet_q >= QW'(LOSS_BITS));

    always_ff @(posedge clk) begin
        if (clear) begin
            fclk_prev <= 1'b0;
            slot_q    <= slot_t'(SLOTS-1);
            framed_q  <= 1'b0;
            quiet_q   <= '0;
        end else begin
            fclk_prev <= fclk_in;
            slot_q    <= slot_now;
            if (rise)
                framed_q <= 1'b1;
            else if (pos.commit)
                framed_q <= 1'b0;
            if (fclk_in != fclk_prev)
                quiet_q <= '0;
            else if (quiet_q != QW'(LOSS_BITS))
                quiet_q <= quiet_q + QW'(1);
        end
    end

    // R4: any transition on the forwarded clock clears the loss flag
    a_r4_toggle_clears_loss: assert property (@(posedge clk) disable iff (rst)
        (fclk_in != fclk_prev) |=> !clk_lost);
endmodule

// File: rtl/deser_lanes.sv
module deser_lanes
    import deser_pkg::*;
(
    input  logic              clk,
    input  logic              clear,
    input  logic [LANES-1:0]  lane_in,
    input  slot_t             slot,
    output logic [WORD_W-1:0] word,
    output logic              any_toggle
);
    logic [LANES-1:0] prev_q;

    assign any_toggle = |(lane_in ^ prev_q);

    always_ff @(posedge clk) begin
        if (clear)
            prev_q <= '0;
        else
            prev_q <= lane_in;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SLOTS-2:0] cap_q;

        always_ff @(posedge clk) begin
            if (clear) begin
                cap_q <= '0;
            end else begin
                for (int s = 0; s < SLOTS-1; s++) begin
                    if (slot == slot_t'(s))
                        cap_q[s] <= lane_in[k];
                end
            end
        end

        for (genvar s = 0; s < SLOTS; s++) begin : g_bit
            if (s == SLOTS-1) begin : g_live
                assign word[k*SLOTS+s] = lane_in[k];
            end else begin : g_held
                assign word[k*SLOTS+s] = cap_q[s];
            end
        end
    end
endmodule

// File: rtl/deser_idle_mon.sv
module deser_idle_mon #(
    parameter int IDLE_FRAMES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic any_toggle,
    input  logic frame_end,
    output logic data_idle
);
    localparam int IW = $clog2(IDLE_FRAMES + 1);

    logic [IW-1:0] cnt_q;

    assign data_idle = (cnt_q == IW'(IDLE_FRAMES));

    always_ff @(posedge clk) begin
        if (clear)
            cnt_q <= '0;
        else if (any_toggle)
            cnt_q <= '0;
        else if (frame_end && !data_idle)
            cnt_q <= cnt_q + IW'(1);
    end

    // R6: lane activity always withdraws the idle declaration
    a_r6_toggle_clears_idle: assert property (@(posedge clk) disable iff (rst)
        any_toggle |=> !data_idle);
endmodule

// File: rtl/deser_outstage.sv
module deser_outstage
    import deser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              pwr_dn_n,
    input  frame_pos_t        pos,
    input  logic [WORD_W-1:0] word,
    input  logic              clk_lost,
    input  logic              data_idle,
    output logic [WORD_W-1:0] par_data,
    output logic              par_clk
);
    fs_mode_e mode_q;
    fs_mode_e mode_nx;

    always_comb begin
        mode_nx = mode_q;
        unique case (mode_q)
            FS_RUN: begin
                if (clk_lost)
                    mode_nx = FS_HOLD;
                else if (data_idle)
                    mode_nx = FS_ONES;
            end
            FS_HOLD, FS_ONES: begin
                if (!clk_lost && !data_idle)
                    mode_nx = FS_RUN;
            end
            default: mode_nx = FS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            mode_q   <= FS_RUN;
            par_data <= '0;
            par_clk  <= 1'b1;
        end else begin
            mode_q  <= mode_nx;
            par_clk <= clk_lost | clk_high_slot(pos.slot);
            unique case (mode_q)
                FS_ONES: par_data <= '1;
                FS_HOLD: par_data <= par_data;
                default: if (pos.commit) par_data <= word;
            endcase
        end
    end

    // R9: power-down forces the fixed output levels
    a_r9_pd_levels: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn_n |=> (par_clk && par_data == '0));
    // R4: a lost forwarded clock parks the parallel clock high
    a_r4_lost_clk_high: assert property (@(posedge clk) disable iff (rst)
        (clk_lost && pwr_dn_n) |=> par_clk);
    // R5: clock-first failsafe keeps the word frozen
    a_r5_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (mode_q == FS_HOLD && pwr_dn_n) |=> $stable(par_data));
    // R6: data-first failsafe drives all ones
    a_r6_ones_level: assert property (@(posedge clk) disable iff (rst)
        (mode_q == FS_ONES && pwr_dn_n) |=> (&par_data));
endmodule

// File: rtl/tri_lane_deser.sv
module tri_lane_deser
    import deser_pkg::*;
#(
    parameter int LOSS_BITS   = 16,
    parameter int IDLE_FRAMES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      pwr_dn_n,
    input  logic                      fclk_in,
    input  logic [2:0]                lane_in,
    output logic [20:0]               par_data,
    output logic                      par_clk
);
    logic              clear;
    frame_pos_t        pos;
    logic              clk_lost;
    logic              data_idle;
    logic              any_toggle;
    logic [WORD_W-1:0] word;

    assign clear = rst | ~pwr_dn_n;

    deser_framer #(.LOSS_BITS(LOSS_BITS)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .fclk_in  (fclk_in),
        .pos      (pos),
        .clk_lost (clk_lost)
    );

    deser_lanes u_lanes (
        .clk        (clk),
        .clear      (clear),
        .lane_in    (lane_in),
        .slot       (pos.slot),
        .word       (word),
        .any_toggle (any_toggle)
    );

    deser_idle_mon #(.IDLE_FRAMES(IDLE_FRAMES)) u_idle (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .any_toggle (any_toggle),
        .frame_end  (pos.frame_end),
        .data_idle  (data_idle)
    );

    deser_outstage u_out (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .pwr_dn_n  (pwr_dn_n),
        .pos       (pos),
        .word      (word),
        .clk_lost  (clk_lost),
        .data_idle (data_idle),
        .par_data  (par_data),
        .par_clk   (par_clk)
    );
endmodule

// File: tb/tri_lane_deser_tb_top.sv
`timescale 1ns/1ps
module tri_lane_deser_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_dn_n = 1'b1;
    logic        fclk_in = 1'b0;
    logic [2:0]  lane_in = 3'b000;
    logic [20:0] par_data;
    logic        par_clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    localparam logic [20:0] VEC [8] = '{
        21'h1FFFFF, 21'h000001, 21'h100000, 21'h155555,
        21'h0AAAAA, 21'h00007F, 21'h1FC000, 21'h012345
    };

    always #4 clk = ~clk;

    tri_lane_deser dut_i (
        .clk(clk), .rst(rst), .pwr_dn_n(pwr_dn_n), .fclk_in(fclk_in),
        .lane_in(lane_in), .par_data(par_data), .par_clk(par_clk)
    );

    task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic f, input logic [2:0] l);
        @(negedge clk);
        fclk_in = f;
        lane_in = l;
        @(posedge clk);
        #2;
    endtask

    task automatic send_frame(input logic [20:0] w, input logic [20:0] exp,
                              input bit chk_data, input bit chk_clk, input string tag);
        for (int s = 0; s < 7; s++) begin
            drive(s <= 3, {w[14+s], w[7+s], w[s]});
            if (chk_clk) check({tag, " R2 clk"}, {20'd0, par_clk}, {20'd0, (s <= 3)});
        end
        if (chk_data) check(tag, par_data, exp);
    endtask

    task automatic no_clock(input int n, input bit toggle);
        for (int i = 0; i < n; i++)
            drive(1'b0, toggle ? ((i % 2) ? 3'b101 : 3'b010) : 3'b000);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        // R10: reset levels
        repeat (3) @(posedge clk);
        #2;
        check("R10 data", par_data, 21'd0);
        check("R10 clk", {20'd0, par_clk}, 21'd1);
        @(negedge clk);
        rst = 1'b0;

        // R1, R2: table walk
        for (int i = 0; i < 8; i++)
            send_frame(VEC[i], VEC[i], 1'b1, 1'b1, "R1 word");

        // R3: frame without a rising forwarded clock leaves the word alone
        send_frame(21'h0F0F0F, 21'h0F0F0F, 1'b1, 1'b0, "R1 word");
        no_clock(7, 1'b1);
        check("R3 no-edge frame", par_data, 21'h0F0F0F);
        send_frame(21'h13579B, 21'h13579B, 1'b1, 1'b0, "R3 next framed");

        // R4, R5: clock lost first
        send_frame(21'h0C3A5E, 21'h0C3A5E, 1'b1, 1'b0, "R1 word");
        no_clock(24, 1'b1);
        for (int i = 0; i < 4; i++) begin
            no_clock(1, 1'b1);
            check("R4 clk high", {20'd0, par_clk}, 21'd1);
            check("R5 hold", par_data, 21'h0C3A5E);
        end

        // R8: recovery after clock loss
        send_frame(21'h155555, 21'h155555, 1'b1, 1'b1, "R8 resume");
        send_frame(21'h0AAAAA, 21'h0AAAAA, 1'b1, 1'b1, "R8 resume");

        // R6: data idle first
        send_frame(21'h1FFFFF, 21'h1FFFFF, 1'b1, 1'b1, "R1 word");
        for (int f = 0; f < 3; f++)
            send_frame(21'd0, 21'd0, 1'b1, 1'b0, "R6 before idle");
        send_frame(21'd0, 21'd0, 1'b0, 1'b0, "R6");
        send_frame(21'd0, 21'h1FFFFF, 1'b1, 1'b1, "R6 ones");
        send_frame(21'd0, 21'h1FFFFF, 1'b1, 1'b1, "R6 ones");

        // R7: clock lost afterwards
        no_clock(24, 1'b0);
        for (int i = 0; i < 3; i++) begin
            no_clock(1, 1'b0);
            check("R7 clk high", {20'd0, par_clk}, 21'd1);
            check("R7 ones", par_data, 21'h1FFFFF);
        end

        // R8: recovery after data-first failsafe
        send_frame(21'h0AAAAA, 21'd0, 1'b0, 1'b0, "R8");
        send_frame(21'h155555, 21'h155555, 1'b1, 1'b1, "R8 resume");

        // R9: power-down
        drive(1'b1, 3'b111);
        @(negedge clk);
        pwr_dn_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            drive(1'b0, 3'b010);
            check("R9 pd data", par_data, 21'd0);
            check("R9 pd clk", {20'd0, par_clk}, 21'd1);
        end
        @(negedge clk);
        pwr_dn_n = 1'b1;
        send_frame(21'h0E1D3C, 21'h0E1D3C, 1'b1, 1'b1, "R9 after release");
        send_frame(21'h012345, 21'h012345, 1'b1, 1'b1, "R9 after release");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule